// File: doc/BRIEF.md
# DDR3 Burst Column Order Sequencer

This block turns one burst request into the order in which the eight column positions of an SDRAM data burst are visited. A one-cycle start pulse carries the three low starting column bits, an ordering choice (sequential or interleaved), a length choice (full eight beats or a four-beat chop) and a direction flag. Over the next eight clock cycles the block presents one 3-bit column offset per cycle. With each offset it gives a valid flag and a drive-enable flag. These flags mark the beats that carry data and separate them from padding beats, which are tri-stated on reads and carry don't-care data on writes.

A chopped burst takes the same eight cycles as a full burst, so the data path behind the block sees one fixed burst time. The request is captured when it is accepted. Input changes and further start pulses have no effect until the burst has ended and the busy output has dropped.

Top module: `bco_seq`

## Requirements
- R1: After reset, and whenever no burst is running, busy_o, beat_valid_o and beat_drive_o are 0 and beat_off_o is 0.
- R2: A start_i pulse seen while busy_o is 0 is accepted. Beat 0 appears in the next cycle. busy_o then stays high for exactly 8 consecutive cycles, with one beat per cycle, and beats 0 to 3 are always valid.
- R3: While busy_o is 1, start_i and the request inputs have no effect. This includes a start in the cycle of beat 7, which does not begin a new burst.
- R4: A full-length read in sequential order presents offset (s AND 4) XOR (i AND 4), ORed with (s + i) mod 4, for beat i and start s. The rotation wraps inside each 4-aligned half.
- R5: A full-length read in interleaved order presents offset s XOR i for beat i.
- R6: A full-length write presents offset i for beat i, for any start value and ordering.
- R7: A chopped read presents the R4 or R5 order for beats 0 to 3 (i < 4). Beats 4 to 7 have valid and drive-enable low.
- R8: A chopped write presents offset 4*s[2] + i on beats 0 to 3, for either ordering, ignoring s[1:0]. Beats 4 to 7 have valid and drive-enable low.
- R9: During a burst, beat_drive_o equals beat_valid_o, and beat_off_o is 0 on every beat whose valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst request |
| col_lo_i | input | 3 | Starting column offset within the burst |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| chop_i | input | 1 | 1 = four-beat chop, 0 = full eight beats |
| is_read_i | input | 1 | 1 = read burst, 0 = write burst |
| busy_o | output | 1 | High during the eight beat cycles |
| beat_off_o | output | 3 | Column offset of the current beat |
| beat_valid_o | output | 1 | Current beat carries data |
| beat_drive_o | output | 1 | Data drivers enabled for the current beat |

## Verification
All outputs are registered at the edge that samples the request. Beat 0 is therefore due one cycle after the start pulse, and beat k is due k cycles after that. busy_o falls at the edge that ends beat 7. The bench drives stimulus just after a falling edge and samples at each following falling edge, so it reads beat k exactly k+1 edges after the start and checks the idle state one cycle after beat 7. A sweep covers every start offset, ordering, length and direction. Some bursts are disturbed by mid-burst and last-beat start pulses carrying different request values, and their expected sequence is unchanged.

// File: rtl/bco_pkg.sv
package bco_pkg;
  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  typedef struct packed {
    order_e ord;
    logic   chop;
    logic   rd;
  } burst_mode_t;
endpackage

// File: rtl/bco_ctrl.sv
module bco_ctrl #(
  parameter int BURST_LEN = 8,
  localparam int BW = $clog2(BURST_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_q,
  output logic          accept,
  output logic          nxt_active,
  output logic [BW-1:0] nxt_beat
);
  localparam logic [BW-1:0] LAST = BW'(BURST_LEN - 1);

  logic [BW-1:0] beat_q;

  assign accept     = start_i && !busy_q;
  assign nxt_active = accept || (busy_q && (beat_q != LAST));
  assign nxt_beat   = accept ? '0 : beat_q + BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      beat_q <= '0;
    end else if (busy_q) begin
      if (beat_q == LAST) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/bco_order.sv
module bco_order
  import bco_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] start,
  input  burst_mode_t      mode,
  input  logic [OFS_W-1:0] beat,
  output logic [OFS_W-1:0] offset,
  output logic             valid
);
  localparam int LW = OFS_W - 1;

  logic [OFS_W-1:0] seq_off, int_off, rd_off, wr_off, raw_off;
  logic [LW-1:0]    low_sum;

  // rotation wraps within one half; the half bit flips with the beat MSB
  assign low_sum = start[LW-1:0] + beat[LW-1:0];
  assign seq_off = {start[OFS_W-1] ^ beat[OFS_W-1], low_sum};
  assign int_off = start ^ beat;
  assign rd_off  = (mode.ord == ORD_INTLV) ? int_off : seq_off;
  // writes: chop keeps only the half select, full length is always linear
  assign wr_off  = mode.chop ? {start[OFS_W-1], beat[LW-1:0]} : beat;
  assign raw_off = mode.rd ? rd_off : wr_off;

  assign valid  = !(mode.chop && beat[OFS_W-1]);
  assign offset = valid ? raw_off : '0;
endmodule

// File: rtl/bco_seq.sv
module bco_seq
  import bco_pkg::*;
#(
  parameter int BURST_LEN = 8,
  localparam int OFS_W = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [OFS_W-1:0] col_lo_i,
  input  logic             interleave_i,
  input  logic             chop_i,
  input  logic             is_read_i,
  output logic             busy_o,
  output logic [OFS_W-1:0] beat_off_o,
  output logic             beat_valid_o,
  output logic             beat_drive_o
);
  logic             accept, nxt_active;
  logic [OFS_W-1:0] nxt_beat;
  logic [OFS_W-1:0] start_q, start_n;
  burst_mode_t      mode_q, mode_n, mode_in;
  logic [OFS_W-1:0] ord_off;
  logic             ord_valid;

  bco_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_q    (busy_o),
    .accept    (accept),
    .nxt_active(nxt_active),
    .nxt_beat  (nxt_beat)
  );

  always_comb begin
    mode_in.ord  = interleave_i ? ORD_INTLV : ORD_SEQ;
    mode_in.chop = chop_i;
    mode_in.rd   = is_read_i;
  end

  assign mode_n  = accept ? mode_in  : mode_q;
  assign start_n = accept ? col_lo_i : start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      mode_q  <= '{ord: ORD_SEQ, chop: 1'b0, rd: 1'b0};
    end else if (accept) begin
      start_q <= col_lo_i;
      mode_q  <= mode_in;
    end
  end

  bco_order #(.OFS_W(OFS_W)) u_order (
    .start (start_n),
    .mode  (mode_n),
    .beat  (nxt_beat),
    .offset(ord_off),
    .valid (ord_valid)
  );

  always_ff @(posedge clk) begin
    if (rst || !nxt_active) begin
      beat_off_o   <= '0;
      beat_valid_o <= 1'b0;
      beat_drive_o <= 1'b0;
    end else begin
      beat_off_o   <= ord_off;
      beat_valid_o <= ord_valid;
      beat_drive_o <= ord_valid;
    end
  end
endmodule

// File: rtl/bco_seq_chk.sv
module bco_seq_chk #(
  parameter int BURST_LEN = 8,
  localparam int OFS_W = $clog2(BURST_LEN),
  localparam int CW = OFS_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             chop_i,
  input logic             is_read_i,
  input logic             busy_o,
  input logic [OFS_W-1:0] beat_off_o,
  input logic             beat_valid_o,
  input logic             beat_drive_o
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + CW'(1);
    else             run_cnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!beat_valid_o && !beat_drive_o && beat_off_o == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && beat_valid_o));

  p_burst_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_cnt < CW'(BURST_LEN)));

  p_burst_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(busy_o)) |-> (run_cnt == CW'(BURST_LEN)));

  p_first_half_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && run_cnt < CW'(BURST_LEN / 2)) |-> beat_valid_o);

  p_last_beat_start_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && run_cnt == CW'(BURST_LEN - 1)) |=> !busy_o);

  p_write_linear_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !is_read_i && !chop_i) |=> (beat_off_o == '0));

  p_flags_match_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (beat_drive_o == beat_valid_o));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !beat_valid_o) |-> (beat_off_o == '0));
endmodule

bind bco_seq bco_seq_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .chop_i      (chop_i),
  .is_read_i   (is_read_i),
  .busy_o      (busy_o),
  .beat_off_o  (beat_off_o),
  .beat_valid_o(beat_valid_o),
  .beat_drive_o(beat_drive_o)
);

// File: tb/tb_bco_seq.sv
`timescale 1ns/1ps
module tb_bco_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] col_lo_i = '0;
  logic       interleave_i = 1'b0;
  logic       chop_i = 1'b0;
  logic       is_read_i = 1'b0;
  logic       busy_o;
  logic [2:0] beat_off_o;
  logic       beat_valid_o;
  logic       beat_drive_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bco_seq dut (
    .clk(clk), .rst(rst), .start_i(start_i), .col_lo_i(col_lo_i),
    .interleave_i(interleave_i), .chop_i(chop_i), .is_read_i(is_read_i),
    .busy_o(busy_o), .beat_off_o(beat_off_o),
    .beat_valid_o(beat_valid_o), .beat_drive_o(beat_drive_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_off(int s, bit il, bit ch, bit rd, int i);
    if (ch && i >= 4) return 0;
    if (!rd) return ch ? ((s / 4) * 4 + i) : i;
    if (il) return s ^ i;
    return ((s & 4) ^ (i & 4)) | ((s + i) % 4);
  endfunction

  function automatic string req_of(bit il, bit ch, bit rd);
    if (rd && ch) return "R7";
    if (!rd && ch) return "R8";
    if (!rd) return "R6";
    return il ? "R5" : "R4";
  endfunction

  task automatic run_burst(int s, bit il, bit ch, bit rd, bit disturb);
    string r;
    int ev;
    r = req_of(il, ch, rd);
    @(negedge clk);
    col_lo_i = 3'(s); interleave_i = il; chop_i = ch; is_read_i = rd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      ev = (ch && i >= 4) ? 0 : 1;
      chk(disturb ? "R3" : "R2", "busy", int'(busy_o), 1);
      chk(r, $sformatf("offset s=%0d il=%0d ch=%0d rd=%0d beat %0d", s, il, ch, rd, i),
          int'(beat_off_o), exp_off(s, il, ch, rd, i));
      chk(r, $sformatf("valid beat %0d", i), int'(beat_valid_o), ev);
      chk("R9", $sformatf("drive beat %0d", i), int'(beat_drive_o), ev);
      if (disturb && i == 3) begin
        start_i = 1'b1; col_lo_i = ~col_lo_i;
        interleave_i = ~il; chop_i = ~ch; is_read_i = ~rd;
      end
      if (disturb && i == 4) start_i = 1'b0;
      if (disturb && i == 7) start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(disturb ? "R3" : "R2", "busy after beat 7", int'(busy_o), 0);
    chk("R1", "idle valid", int'(beat_valid_o), 0);
    chk("R1", "idle offset", int'(beat_off_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset valid", int'(beat_valid_o), 0);
    chk("R1", "reset drive", int'(beat_drive_o), 0);
    chk("R1", "reset offset", int'(beat_off_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "idle busy", int'(busy_o), 0);
    for (int s = 0; s < 8; s++)
      for (int il = 0; il < 2; il++)
        for (int ch = 0; ch < 2; ch++)
          for (int rd = 0; rd < 2; rd++)
            run_burst(s, il[0], ch[0], rd[0], (s == 3 || s == 6));
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule